// File: doc/BRIEF.md
# Pipelined 64-bit multiply-accumulate unit

This block multiplies two 32-bit operands, or one operand and a sign-extended 16-bit constant, and folds the 64-bit product into an accumulator. The accumulator is held as an upper word and a lower word. The unit can load the product directly, add it to the accumulator, or subtract it from the accumulator. It offers signed and unsigned forms of each operation. Signed forms report overflow on a dedicated flag. Unsigned forms report carry or borrow on a second flag.

An operation is presented for one cycle together with the overflow-exception enable. The block registers the product in a first stage. It then updates the accumulator and the flag in a second stage, and pulses a result strobe. The same cycle also carries an exception request if the flag just written is set and the enable was high. Software can read both accumulator words at any time. It can write either word when no operation is moving through the pipeline.

Top module: `mac64_unit`

## Requirements
- R1: After reset both accumulator words read zero, both flags are clear, and `res_valid_o`, `exc_req_o` and `busy_o` are low.
- R2: Opcode 0 loads the signed 64-bit product of `op_a_i` and `op_b_i` into the accumulator, and opcode 1 loads the unsigned product. Bits 63..32 go to `acc_hi_o` and bits 31..0 go to `acc_lo_o`. Neither flag changes and no exception is requested.
- R3: Opcode 2 adds the signed product to the joined {hi,lo} accumulator. It sets `flag_ov_o` to the signed 64-bit overflow of that addition and leaves `flag_cy_o` unchanged.
- R4: Opcode 4 multiplies the sign-extended `op_imm_i` by signed `op_a_i` and otherwise behaves as opcode 2. `op_b_i` has no effect on it.
- R5: Opcode 3 adds the unsigned product to the accumulator. It sets `flag_cy_o` to the carry out of bit 63 and leaves `flag_ov_o` unchanged.
- R6: Opcode 5 computes accumulator minus signed product. It sets `flag_ov_o` to the signed 64-bit overflow of that subtraction and leaves `flag_cy_o` unchanged.
- R7: Opcode 6 computes accumulator minus unsigned product. It sets `flag_cy_o` to the borrow and leaves `flag_ov_o` unchanged.
- R8: For opcodes 2 to 6, `exc_req_o` is high with the result strobe exactly when the flag written by that operation is 1 and `ovf_exc_en_i` was high with the operation. The accumulator is updated in either case.
- R9: `res_valid_o` pulses for one cycle two clock edges after an operation is accepted. `busy_o` is high in the cycle between those edges.
- R10: A write request on `acc_wr_hi_i` or `acc_wr_lo_i` loads `acc_wr_data_i` into that word at the next edge. The request is ignored when `op_valid_i` or `busy_o` is high in the same cycle.
- R11: Opcode 7 is not accepted. It produces no strobe, does not raise `busy_o`, and changes neither the accumulator nor the flags.
- R12: Operations issued on consecutive cycles chain. Each one uses the accumulator left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 3 | Operation select (encoding in R2 to R7, R11) |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| op_imm_i | input | 16 | Signed constant for opcode 4 |
| ovf_exc_en_i | input | 1 | Exception enable, sampled with the operation |
| acc_wr_hi_i | input | 1 | Write request for the upper word |
| acc_wr_lo_i | input | 1 | Write request for the lower word |
| acc_wr_data_i | input | 32 | Data for accumulator word writes |
| acc_hi_o | output | 32 | Accumulator bits 63..32 |
| acc_lo_o | output | 32 | Accumulator bits 31..0 |
| flag_ov_o | output | 1 | Signed overflow flag |
| flag_cy_o | output | 1 | Carry / borrow flag |
| res_valid_o | output | 1 | Result strobe |
| exc_req_o | output | 1 | Range exception request, valid with the strobe |
| busy_o | output | 1 | Operation in flight |

## Verification
The hardest cases to reach from the ports are the 64-bit overflow boundaries. These need the accumulator to sit exactly at the signed maximum, the signed minimum or all ones before the operation. The bench therefore preloads both words through the software write path before each table vector, so that a product of 1 or 2 crosses the boundary. Two directed sequences cover write blocking and chaining. One places a write request in the issue cycle and another in the busy cycle. The other issues two accumulations on adjacent cycles, so that the second consumes a result that has only just been written.

// File: rtl/mac64_pkg.sv
package mac64_pkg;

    typedef enum logic [2:0] {
        MOP_MULS  = 3'd0,
        MOP_MULU  = 3'd1,
        MOP_MADDS = 3'd2,
        MOP_MADDU = 3'd3,
        MOP_MADDI = 3'd4,
        MOP_MSUBS = 3'd5,
        MOP_MSUBU = 3'd6,
        MOP_NONE  = 3'd7
    } macop_e;

    function automatic logic op_is_load(macop_e o);
        return (o == MOP_MULS) || (o == MOP_MULU);
    endfunction

    function automatic logic op_is_sub(macop_e o);
        return (o == MOP_MSUBS) || (o == MOP_MSUBU);
    endfunction

    function automatic logic op_is_signed(macop_e o);
        return (o == MOP_MULS) || (o == MOP_MADDS) || (o == MOP_MADDI) || (o == MOP_MSUBS);
    endfunction

    function automatic logic op_uses_imm(macop_e o);
        return (o == MOP_MADDI);
    endfunction

endpackage

// File: rtl/mac64_mult.sv
module mac64_mult
    import mac64_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  macop_e              op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [IMM_W-1:0]    imm_i,
    output logic [2*DATA_W-1:0] prod_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = DATA_W + 1;

    logic               sgn;
    logic signed [EXT_W-1:0]  xa, xb;
    logic signed [PROD_W-1:0] wa, wb;

    // Both operands widen to DATA_W+1 bits, so that one signed multiplier serves both signednesses.
    always_comb begin
        sgn = op_is_signed(op_i);
        xa  = {sgn & a_i[DATA_W-1], a_i};
        if (op_uses_imm(op_i)) begin
            xb = {{(EXT_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        end else begin
            xb = {sgn & b_i[DATA_W-1], b_i};
        end
        wa     = PROD_W'(xa);
        wb     = PROD_W'(xb);
        prod_o = wa * wb;
    end

endmodule

// File: rtl/mac64_accum.sv
module mac64_accum #(
    parameter int ACC_W = 64
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] prod_i,
    input  logic             sub_i,
    output logic [ACC_W-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W:0] ext;

    always_comb begin
        if (sub_i) begin
            ext   = {1'b0, acc_i} - {1'b0, prod_i};
            ovf_o = (acc_i[MSB] != prod_i[MSB]) && (ext[MSB] != acc_i[MSB]);
        end else begin
            ext   = {1'b0, acc_i} + {1'b0, prod_i};
            ovf_o = (acc_i[MSB] == prod_i[MSB]) && (ext[MSB] != acc_i[MSB]);
        end
        res_o   = ext[MSB:0];
        carry_o = ext[ACC_W];
    end

    // A borrow means that the product exceeded the accumulator as an unsigned value.
    always_comb begin
        if (sub_i && (prod_i == '0)) begin
            AST_ZERO_SUB_NO_BORROW: assert (!carry_o && res_o == acc_i); // R7
        end
    end

endmodule

// File: rtl/mac64_unit.sv
module mac64_unit
    import mac64_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [IMM_W-1:0]  op_imm_i,
    input  logic              ovf_exc_en_i,
    input  logic              acc_wr_hi_i,
    input  logic              acc_wr_lo_i,
    input  logic [DATA_W-1:0] acc_wr_data_i,
    output logic [DATA_W-1:0] acc_hi_o,
    output logic [DATA_W-1:0] acc_lo_o,
    output logic              flag_ov_o,
    output logic              flag_cy_o,
    output logic              res_valid_o,
    output logic              exc_req_o,
    output logic              busy_o
);
    localparam int ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic              s1_vld;
        macop_e            s1_op;
        logic [ACC_W-1:0]  s1_prod;
        logic              s1_exc_en;
        logic [DATA_W-1:0] acc_hi;
        logic [DATA_W-1:0] acc_lo;
        logic              ov;
        logic              cy;
        logic              res_vld;
        logic              exc;
    } st_t;

    st_t st_d, st_q;

    macop_e           op_in;
    logic             accept;
    logic             wr_ok;
    logic [ACC_W-1:0] mult_prod;
    logic [ACC_W-1:0] sum_res;
    logic             sum_carry;
    logic             sum_ovf;

    assign op_in  = macop_e'(op_code_i);
    assign accept = op_valid_i && (op_in != MOP_NONE);
    assign wr_ok  = !op_valid_i && !st_q.s1_vld;

    mac64_mult #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) mult_i (
        .op_i   (op_in),
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .imm_i  (op_imm_i),
        .prod_o (mult_prod)
    );

    mac64_accum #(
        .ACC_W (ACC_W)
    ) accum_i (
        .acc_i   ({st_q.acc_hi, st_q.acc_lo}),
        .prod_i  (st_q.s1_prod),
        .sub_i   (op_is_sub(st_q.s1_op)),
        .res_o   (sum_res),
        .carry_o (sum_carry),
        .ovf_o   (sum_ovf)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res_vld = 1'b0;
        st_d.exc     = 1'b0;

        // Stage 1: capture the product.
        st_d.s1_vld = accept;
        if (accept) begin
            st_d.s1_op     = op_in;
            st_d.s1_prod   = mult_prod;
            st_d.s1_exc_en = ovf_exc_en_i;
        end

        // Stage 2: fold the product into the accumulator and update one flag.
        if (st_q.s1_vld) begin
            st_d.res_vld = 1'b1;
            if (op_is_load(st_q.s1_op)) begin
                {st_d.acc_hi, st_d.acc_lo} = st_q.s1_prod;
            end else begin
                {st_d.acc_hi, st_d.acc_lo} = sum_res;
                if (op_is_signed(st_q.s1_op)) begin
                    st_d.ov  = sum_ovf;
                    st_d.exc = sum_ovf && st_q.s1_exc_en;
                end else begin
                    st_d.cy  = sum_carry;
                    st_d.exc = sum_carry && st_q.s1_exc_en;
                end
            end
        end else if (wr_ok) begin
            if (acc_wr_hi_i) st_d.acc_hi = acc_wr_data_i;
            if (acc_wr_lo_i) st_d.acc_lo = acc_wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi_o    = st_q.acc_hi;
    assign acc_lo_o    = st_q.acc_lo;
    assign flag_ov_o   = st_q.ov;
    assign flag_cy_o   = st_q.cy;
    assign res_valid_o = st_q.res_vld;
    assign exc_req_o   = st_q.exc;
    assign busy_o      = st_q.s1_vld;

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i != 3'd7) |-> ##2 res_valid_o); // R9

    AST_RSVD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == 3'd7) |=> !busy_o); // R11

    AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !acc_wr_hi_i && !acc_wr_lo_i) |=> $stable({acc_hi_o, acc_lo_o})); // R10

    AST_EXC_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (res_valid_o && (flag_ov_o || flag_cy_o))); // R8

    AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_is_load(st_q.s1_op)) |=> ($stable(flag_ov_o) && $stable(flag_cy_o) && !exc_req_o)); // R2

    AST_SIGNED_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_is_signed(st_q.s1_op)) |=> $stable(flag_cy_o)); // R3

    AST_UNSIGNED_KEEPS_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !op_is_signed(st_q.s1_op)) |=> $stable(flag_ov_o)); // R5

endmodule

// File: tb/mac64_unit_tb_top.sv
`timescale 1ns/1ps
module mac64_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [2:0]  op_code_i = '0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [15:0] op_imm_i = '0;
    logic        ovf_exc_en_i = 1'b0;
    logic        acc_wr_hi_i = 1'b0;
    logic        acc_wr_lo_i = 1'b0;
    logic [31:0] acc_wr_data_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        flag_ov_o, flag_cy_o, res_valid_o, exc_req_o, busy_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mac64_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid_i    (op_valid_i),
        .op_code_i     (op_code_i),
        .op_a_i        (op_a_i),
        .op_b_i        (op_b_i),
        .op_imm_i      (op_imm_i),
        .ovf_exc_en_i  (ovf_exc_en_i),
        .acc_wr_hi_i   (acc_wr_hi_i),
        .acc_wr_lo_i   (acc_wr_lo_i),
        .acc_wr_data_i (acc_wr_data_i),
        .acc_hi_o      (acc_hi_o),
        .acc_lo_o      (acc_lo_o),
        .flag_ov_o     (flag_ov_o),
        .flag_cy_o     (flag_cy_o),
        .res_valid_o   (res_valid_o),
        .exc_req_o     (exc_req_o),
        .busy_o        (busy_o)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        en;
        logic [31:0] pre_hi;
        logic [31:0] pre_lo;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
        logic        exp_flag;
        logic        exp_exc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'hFFFFFFFE, 32'h00000003, 16'h0000, 1'b1, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFA, 1'b0, 1'b0},
        '{3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 1'b1, 32'h0, 32'h0, 32'hFFFFFFFE, 32'h00000001, 1'b0, 1'b0},
        '{3'd2, 32'h00000002, 32'h00000003, 16'h0000, 1'b1, 32'h0, 32'h10, 32'h00000000, 32'h00000016, 1'b0, 1'b0},
        '{3'd2, 32'h00000001, 32'h00000001, 16'h0000, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b1},
        '{3'd2, 32'h00000001, 32'h00000001, 16'h0000, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0},
        '{3'd3, 32'h00000001, 32'h00000002, 16'h0000, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b1, 1'b1},
        '{3'd3, 32'h00010000, 32'h00010000, 16'h0000, 1'b1, 32'h1, 32'h0, 32'h00000002, 32'h00000000, 1'b0, 1'b0},
        '{3'd4, 32'h00000005, 32'h12345678, 16'hFFFD, 1'b1, 32'h0, 32'h64, 32'h00000000, 32'h00000055, 1'b0, 1'b0},
        '{3'd5, 32'h00000001, 32'h00000001, 16'h0000, 1'b1, 32'h80000000, 32'h0, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1},
        '{3'd5, 32'hFFFFFFFF, 32'h00000004, 16'h0000, 1'b1, 32'h0, 32'hA, 32'h00000000, 32'h0000000E, 1'b0, 1'b0},
        '{3'd6, 32'h00000002, 32'h00000002, 16'h0000, 1'b1, 32'h0, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1},
        '{3'd6, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b1, 32'h1, 32'h0, 32'h00000000, 32'h00000001, 1'b0, 1'b0},
        '{3'd2, 32'h80000000, 32'h80000000, 16'h0000, 1'b1, 32'h0, 32'h0, 32'h40000000, 32'h00000000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3";
            3'd3:       return "R5";
            3'd4:       return "R4";
            3'd5:       return "R6";
            default:    return "R7";
        endcase
    endfunction

    task automatic preload(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        acc_wr_hi_i = 1'b1; acc_wr_data_i = hi;
        @(negedge clk);
        acc_wr_hi_i = 1'b0; acc_wr_lo_i = 1'b1; acc_wr_data_i = lo;
        @(negedge clk);
        acc_wr_lo_i = 1'b0;
    endtask

    task automatic drive_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] imm, input logic en);
        op_valid_i = 1'b1; op_code_i = op; op_a_i = a; op_b_i = b;
        op_imm_i = imm; ovf_exc_en_i = en;
    endtask

    task automatic run_vec(input vec_t v);
        logic ov0, cy0;
        string rq;
        rq = req_of(v.op);
        preload(v.pre_hi, v.pre_lo);
        ov0 = flag_ov_o; cy0 = flag_cy_o;
        @(negedge clk);
        drive_op(v.op, v.a, v.b, v.imm, v.en);
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R9", "busy mid-flight", {31'b0, busy_o}, 32'd1);
        check("R9", "no early strobe", {31'b0, res_valid_o}, 32'd0);
        @(negedge clk);
        check("R9", "strobe", {31'b0, res_valid_o}, 32'd1);
        check(rq, "acc_hi", acc_hi_o, v.exp_hi);
        check(rq, "acc_lo", acc_lo_o, v.exp_lo);
        if (v.op <= 3'd1) begin
            check(rq, "ov kept", {31'b0, flag_ov_o}, {31'b0, ov0});
            check(rq, "cy kept", {31'b0, flag_cy_o}, {31'b0, cy0});
        end else if (v.op == 3'd2 || v.op == 3'd4 || v.op == 3'd5) begin
            check(rq, "ov", {31'b0, flag_ov_o}, {31'b0, v.exp_flag});
            check(rq, "cy kept", {31'b0, flag_cy_o}, {31'b0, cy0});
        end else begin
            check(rq, "cy", {31'b0, flag_cy_o}, {31'b0, v.exp_flag});
            check(rq, "ov kept", {31'b0, flag_ov_o}, {31'b0, ov0});
        end
        check("R8", "exception", {31'b0, exc_req_o}, {31'b0, v.exp_exc});
        @(negedge clk);
        check("R9", "strobe one cycle", {31'b0, res_valid_o}, 32'd0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "acc_hi", acc_hi_o, 32'h0);
        check("R1", "acc_lo", acc_lo_o, 32'h0);
        check("R1", "flags", {30'b0, flag_ov_o, flag_cy_o}, 32'h0);
        check("R1", "strobes", {29'b0, res_valid_o, exc_req_o, busy_o}, 32'h0);

        // R10: write takes effect at the next edge
        @(negedge clk);
        acc_wr_hi_i = 1'b1; acc_wr_data_i = 32'hCAFE0001;
        @(negedge clk);
        acc_wr_hi_i = 1'b0;
        check("R10", "hi write", acc_hi_o, 32'hCAFE0001);
        check("R10", "lo untouched", acc_lo_o, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: write in the busy cycle is ignored
        preload(32'h0, 32'h0);
        @(negedge clk);
        drive_op(3'd1, 32'd7, 32'd6, 16'h0, 1'b0);
        @(negedge clk);
        op_valid_i = 1'b0; acc_wr_lo_i = 1'b1; acc_wr_data_i = 32'hDEAD;
        @(negedge clk);
        acc_wr_lo_i = 1'b0;
        check("R10", "busy write dropped", acc_lo_o, 32'd42);

        // R10: write in the issue cycle is ignored
        @(negedge clk);
        drive_op(3'd1, 32'd3, 32'd3, 16'h0, 1'b0);
        acc_wr_hi_i = 1'b1; acc_wr_data_i = 32'h55;
        @(negedge clk);
        op_valid_i = 1'b0; acc_wr_hi_i = 1'b0;
        @(negedge clk);
        check("R10", "issue write dropped hi", acc_hi_o, 32'h0);
        check("R10", "issue write dropped lo", acc_lo_o, 32'd9);

        // R11: reserved opcode has no effect
        preload(32'h1234, 32'h5678);
        @(negedge clk);
        drive_op(3'd7, 32'd9, 32'd9, 16'h0, 1'b1);
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R11", "not busy", {31'b0, busy_o}, 32'd0);
        @(negedge clk);
        check("R11", "no strobe", {31'b0, res_valid_o}, 32'd0);
        check("R11", "acc_hi kept", acc_hi_o, 32'h1234);
        check("R11", "acc_lo kept", acc_lo_o, 32'h5678);

        // R12: back-to-back accumulation chains
        preload(32'h0, 32'h0);
        @(negedge clk);
        drive_op(3'd2, 32'd2, 32'd3, 16'h0, 1'b0);
        @(negedge clk);
        drive_op(3'd2, 32'd4, 32'd5, 16'h0, 1'b0);
        @(negedge clk);
        op_valid_i = 1'b0;
        check("R12", "first result", acc_lo_o, 32'd6);
        @(negedge clk);
        check("R12", "chained result", acc_lo_o, 32'd26);
        check("R12", "second strobe", {31'b0, res_valid_o}, 32'd1);

        report();
        $finish;
    end

endmodule